// File: doc/BRIEF.md
# Dependency-Checking Multi-Unit Instruction Issuer

This block sits between an instruction-sending controller and a small pool of modular arithmetic units that share one operand RAM. The controller offers one 32-bit instruction per cycle. Each instruction names a result register and three source registers in that RAM. The block holds the instructions in a short queue and looks for read-after-write conflicts across the whole queue. It hands every instruction that is free of conflicts to an idle unit. Several units can start in the same cycle, and a younger instruction may overtake a blocked older one. When the queue is full, a full flag tells the controller to hold its current instruction.

Each arithmetic unit is a stand-in with a fixed, configurable latency. A unit has two states. In IDLE it waits. The transition IDLE→RUN happens on an issue grant, and it captures the result register. In RUN the unit counts down. The transition RUN→IDLE happens in the cycle its counter reaches zero, and `unit_done` is high in that cycle. While a unit is in RUN, its result register is pending. Any instruction that reads a pending register is held.

The queue keeps its entries in arrival order. Entries that issue are removed in the same clock edge that appends a newly accepted instruction, and the survivors keep their relative order.

Top module: `raw_issue_queue`

## Requirements
- R1: Instruction fields are: opcode bits [31:28], result R bits [27:21], source X bits [20:14], source Y bits [13:7], source S bits [6:0]. An issued unit's `issue_word` slice carries the queued instruction unchanged.
- R2: An instruction on `in_word` is accepted at a clock edge when `in_valid` is high and `full` is low. `full` is high exactly while DEPTH entries are held. A held instruction is accepted only after `full` drops.
- R3: An instruction whose X, Y or S equals the R of any older queued instruction does not issue while that older instruction is still queued.
- R4: An instruction whose R equals the X, Y or S of any older queued instruction does not issue while that older instruction is still queued.
- R5: Equal result registers alone do not block. Two instructions with the same R and no source/result overlap issue independently, and the younger may issue first.
- R6: An instruction whose X, Y or S equals the R of a unit in RUN is held. With latency L, it can issue at the earliest L+1 cycles after the producer's issue cycle.
- R7: Each cycle, the ready entries are taken oldest first and each goes to the lowest-numbered idle unit. Several may issue in one cycle, and a ready younger entry issues past a blocked older one.
- R8: A unit that was issued in cycle t is in RUN for cycles t+1 to t+L. `unit_done` is high only in cycle t+L, and the unit takes no issue while in RUN.
- R9: After reset the queue is empty, `full` is low, and no `issue_valid` or `unit_done` is high.
- R10: Every accepted instruction is issued exactly once, and the entries that are not issued keep their arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Controller offers an instruction |
| in_word | input | 32 | Offered instruction |
| full | output | 1 | Queue holds DEPTH entries; controller must hold |
| issue_valid | output | NUM_UNITS | Per-unit start strobe this cycle |
| issue_word | output | 32*NUM_UNITS | Instruction started on each unit (unit u at bits 32u+31:32u) |
| unit_done | output | NUM_UNITS | Per-unit completion pulse |

## Verification
The bench builds the block with three units, a queue depth of four and a unit latency of five. This latency is long enough that a producer still pending can back the queue up to full while the controller keeps offering. Three units are fewer than the ready entries released in one cycle, so the oldest-first, lowest-unit allocation and the leftover waiting entry are both exercised. A younger independent instruction also lands in the middle of that release and overtakes the held entries.

// File: rtl/riq_pkg.sv
package riq_pkg;

    localparam int WORD_W = 32;
    localparam int REG_W  = 7;
    localparam int OP_W   = 4;

    typedef logic [REG_W-1:0] reg_addr_t;

    // Packed MSB first: opcode, result, X, Y, S
    typedef struct packed {
        logic [OP_W-1:0] op;
        reg_addr_t       dst;
        reg_addr_t       src_x;
        reg_addr_t       src_y;
        reg_addr_t       src_s;
    } instr_t;

    function automatic logic reads_reg(instr_t ins, reg_addr_t a);
        return (ins.src_x == a) || (ins.src_y == a) || (ins.src_s == a);
    endfunction

    // True when the younger entry must wait for the older one (either direction)
    function automatic logic pair_conflict(instr_t older, instr_t younger);
        return reads_reg(younger, older.dst) || reads_reg(older, younger.dst);
    endfunction

endpackage

// File: rtl/riq_unit.sv
module riq_unit
    import riq_pkg::*;
#(
    parameter int LATENCY = 5
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  reg_addr_t dst_in,
    output logic      busy,
    output logic      done,
    output reg_addr_t dst
);

    localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;

    typedef enum logic {U_IDLE, U_RUN} ustate_t;

    ustate_t       state, state_n;
    logic [CW-1:0] cnt, cnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= U_IDLE;
            cnt   <= '0;
            dst   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            if (start) begin
                dst <= dst_in;
            end
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            U_IDLE: begin
                if (start) begin
                    state_n = U_RUN;
                    cnt_n   = CW'(LATENCY - 1);
                end
            end
            U_RUN: begin
                if (cnt == '0) begin
                    state_n = U_IDLE;
                end else begin
                    cnt_n = cnt - CW'(1);
                end
            end
            default: state_n = U_IDLE;
        endcase
    end

    always_comb begin
        busy = (state == U_RUN);
        done = (state == U_RUN) && (cnt == '0);
    end

endmodule

// File: rtl/riq_store.sv
module riq_store
    import riq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              push,
    input  instr_t                            push_word,
    input  logic [DEPTH-1:0]                  pop_mask,
    output instr_t [DEPTH-1:0]                slot,
    output logic [DEPTH-1:0]                  slot_valid,
    output logic [$clog2(DEPTH+1)-1:0]        occ,
    output logic                              full
);

    localparam int OCC_W = $clog2(DEPTH + 1);

    instr_t [DEPTH-1:0] slot_n;
    logic [OCC_W-1:0]   occ_n;
    int                 fill;

    for (genvar k = 0; k < DEPTH; k++) begin : g_valid
        assign slot_valid[k] = (OCC_W'(k) < occ);
    end

    assign full = (occ == OCC_W'(DEPTH));

    // Compaction: survivors slide down in order, then the new entry lands on top
    always_comb begin
        slot_n = slot;
        fill   = 0;
        for (int k = 0; k < DEPTH; k++) begin
            if (slot_valid[k] && !pop_mask[k]) begin
                slot_n[fill] = slot[k];
                fill         = fill + 1;
            end
        end
        if (push && (fill < DEPTH)) begin
            slot_n[fill] = push_word;
            fill         = fill + 1;
        end
        occ_n = OCC_W'(fill);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
            occ  <= '0;
        end else begin
            slot <= slot_n;
            occ  <= occ_n;
        end
    end

endmodule

// File: rtl/riq_hazard.sv
module riq_hazard
    import riq_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int NUM_UNITS = 2
) (
    input  instr_t [DEPTH-1:0]        slot,
    input  logic [DEPTH-1:0]          slot_valid,
    input  logic [NUM_UNITS-1:0]      unit_busy,
    input  reg_addr_t [NUM_UNITS-1:0] unit_dst,
    output logic [DEPTH-1:0]          ready
);

    logic [DEPTH-1:0] held_pending;
    logic [DEPTH-1:0] held_order;

    // Sources against results still in flight
    always_comb begin
        held_pending = '0;
        for (int k = 0; k < DEPTH; k++) begin
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (unit_busy[u] && reads_reg(slot[k], unit_dst[u])) begin
                    held_pending[k] = 1'b1;
                end
            end
        end
    end

    // Pairwise window search; entry 0 has no older neighbour
    always_comb begin
        held_order = '0;
        for (int k = 1; k < DEPTH; k++) begin
            for (int i = 0; i < k; i++) begin
                if (pair_conflict(slot[i], slot[k])) begin
                    held_order[k] = 1'b1;
                end
            end
        end
    end

    assign ready = slot_valid & ~held_pending & ~held_order;

endmodule

// File: rtl/riq_pick.sv
module riq_pick #(
    parameter int DEPTH     = 4,
    parameter int NUM_UNITS = 2,
    localparam int SW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]              ready,
    input  logic [NUM_UNITS-1:0]          unit_busy,
    output logic [DEPTH-1:0]              grant,
    output logic [NUM_UNITS-1:0]          start,
    output logic [NUM_UNITS-1:0][SW-1:0]  pick_idx
);

    logic [NUM_UNITS-1:0] taken;
    logic                 placed;

    always_comb begin
        taken    = '0;
        grant    = '0;
        start    = '0;
        pick_idx = '0;
        placed   = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            placed = 1'b0;
            if (ready[k]) begin
                for (int u = 0; u < NUM_UNITS; u++) begin
                    if (!placed && !unit_busy[u] && !taken[u]) begin
                        taken[u]    = 1'b1;
                        start[u]    = 1'b1;
                        pick_idx[u] = SW'(k);
                        grant[k]    = 1'b1;
                        placed      = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/raw_issue_queue.sv
module raw_issue_queue
    import riq_pkg::*;
#(
    parameter int NUM_UNITS = 2,
    parameter int DEPTH     = 4,
    parameter int LATENCY   = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [31:0]                 in_word,
    output logic                        full,
    output logic [NUM_UNITS-1:0]        issue_valid,
    output logic [NUM_UNITS*32-1:0]     issue_word,
    output logic [NUM_UNITS-1:0]        unit_done
);

    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    instr_t [DEPTH-1:0]            slot;
    logic [DEPTH-1:0]              slot_valid;
    logic [OCC_W-1:0]              occ;
    logic                          push;
    logic [DEPTH-1:0]              ready;
    logic [DEPTH-1:0]              grant;
    logic [NUM_UNITS-1:0]          unit_busy;
    reg_addr_t [NUM_UNITS-1:0]     unit_dst;
    logic [NUM_UNITS-1:0][SW-1:0]  pick_idx;

    assign push = in_valid && !full;

    riq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_word  (instr_t'(in_word)),
        .pop_mask   (grant),
        .slot       (slot),
        .slot_valid (slot_valid),
        .occ        (occ),
        .full       (full)
    );

    riq_hazard #(.DEPTH(DEPTH), .NUM_UNITS(NUM_UNITS)) u_hazard (
        .slot       (slot),
        .slot_valid (slot_valid),
        .unit_busy  (unit_busy),
        .unit_dst   (unit_dst),
        .ready      (ready)
    );

    riq_pick #(.DEPTH(DEPTH), .NUM_UNITS(NUM_UNITS)) u_pick (
        .ready     (ready),
        .unit_busy (unit_busy),
        .grant     (grant),
        .start     (issue_valid),
        .pick_idx  (pick_idx)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        instr_t chosen;
        assign chosen = slot[pick_idx[u]];
        assign issue_word[u*32 +: 32] = issue_valid[u] ? 32'(chosen) : 32'd0;

        riq_unit #(.LATENCY(LATENCY)) u_exec (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (issue_valid[u]),
            .dst_in (chosen.dst),
            .busy   (unit_busy[u]),
            .done   (unit_done[u]),
            .dst    (unit_dst[u])
        );
    end

endmodule

// File: rtl/riq_chk.sv
module riq_chk #(
    parameter int NUM_UNITS = 2,
    parameter int DEPTH     = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          push,
    input logic [$clog2(DEPTH+1)-1:0]    occ,
    input logic [NUM_UNITS-1:0]          issue_valid,
    input logic [NUM_UNITS*32-1:0]       issue_word,
    input logic [NUM_UNITS-1:0]          done,
    input logic [NUM_UNITS-1:0]          unit_busy,
    input logic [NUM_UNITS*7-1:0]        unit_dst
);

    // R2: occupancy never exceeds the queue depth
    a_r2_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ) <= DEPTH);

    // R10: occupancy moves by accepted minus issued
    a_r10_occ_update: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> int'(occ) == int'($past(occ)) + int'($past(push))
                                      - $countones($past(issue_valid)));

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_u
        // R8: a started unit runs next cycle and cannot restart
        a_r8_run_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid[u] |=> unit_busy[u] && !issue_valid[u]);

        // R8: completion only from a running unit that is not restarting
        a_r8_done_in_run: assert property (@(posedge clk) disable iff (!rst_n)
            done[u] |-> unit_busy[u] && !issue_valid[u]);

        for (genvar v = 0; v < NUM_UNITS; v++) begin : g_v
            // R6: nothing issues that reads a result still in flight
            a_r6_no_pending_read: assert property (@(posedge clk) disable iff (!rst_n)
                (issue_valid[u] && unit_busy[v]) |->
                    (issue_word[u*32+14 +: 7] != unit_dst[v*7 +: 7]) &&
                    (issue_word[u*32+7  +: 7] != unit_dst[v*7 +: 7]) &&
                    (issue_word[u*32    +: 7] != unit_dst[v*7 +: 7]));
        end
    end

endmodule

bind raw_issue_queue riq_chk #(.NUM_UNITS(NUM_UNITS), .DEPTH(DEPTH)) u_riq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push),
    .occ         (occ),
    .issue_valid (issue_valid),
    .issue_word  (issue_word),
    .done        (unit_done),
    .unit_busy   (unit_busy),
    .unit_dst    (unit_dst)
);

// File: tb/test_raw_issue_queue.sv
`timescale 1ns/1ps
module test_raw_issue_queue;

    localparam int NU  = 3;
    localparam int DEP = 4;
    localparam int LAT = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic [31:0]        in_word = '0;
    logic               full;
    logic [NU-1:0]      issue_valid;
    logic [NU*32-1:0]   issue_word;
    logic [NU-1:0]      unit_done;

    raw_issue_queue #(.NUM_UNITS(NU), .DEPTH(DEP), .LATENCY(LAT)) i_raw_issue_queue (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .full(full), .issue_valid(issue_valid), .issue_word(issue_word),
        .unit_done(unit_done)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int sent = 0;
    int full_seen = 0;
    logic [31:0] src_q[$];
    logic [31:0] mq[$];
    int ubusy[NU];
    int ucnt[NU];
    int udst[NU];
    int iss_cyc[logic [31:0]];
    int iss_num[logic [31:0]];

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] mk(int op, int r, int x, int y, int s);
        return {4'(op), 7'(r), 7'(x), 7'(y), 7'(s)};
    endfunction

    function automatic int dstf(logic [31:0] w);
        return int'(w[27:21]);
    endfunction

    function automatic bit rd(logic [31:0] w, int a);
        return (int'(w[20:14]) == a) || (int'(w[13:7]) == a) || (int'(w[6:0]) == a);
    endfunction

    function automatic int iss(logic [31:0] w);
        return iss_cyc.exists(w) ? iss_cyc[w] : -1;
    endfunction

    // One cycle: drive inputs, compare against the reference model, advance it
    task automatic step();
        int          pick[NU];
        bit          gone[DEP];
        bit          e_full;
        bit          acc;
        logic [31:0] nq[$];
        @(negedge clk);
        in_valid = (src_q.size() > 0);
        in_word  = (src_q.size() > 0) ? src_q[0] : 32'd0;
        e_full   = (mq.size() == DEP);
        for (int u = 0; u < NU; u++) pick[u] = -1;
        for (int k = 0; k < DEP; k++) gone[k] = 1'b0;
        for (int k = 0; k < mq.size(); k++) begin
            bit blk = 1'b0;
            for (int u = 0; u < NU; u++)
                if (ubusy[u] != 0 && rd(mq[k], udst[u])) blk = 1'b1;
            for (int i = 0; i < k; i++)
                if (rd(mq[k], dstf(mq[i])) || rd(mq[i], dstf(mq[k]))) blk = 1'b1;
            if (!blk) begin
                for (int u = 0; u < NU; u++) begin
                    if (!gone[k] && ubusy[u] == 0 && pick[u] < 0) begin
                        pick[u] = k;
                        gone[k] = 1'b1;
                    end
                end
            end
        end
        check(full == e_full, "R2", "full", 32'(full), 32'(e_full));
        for (int u = 0; u < NU; u++) begin
            logic [31:0] w = issue_word[u*32 +: 32];
            bit e_done = (ubusy[u] != 0) && (ucnt[u] == 0);
            check(issue_valid[u] == (pick[u] >= 0), "R7", $sformatf("issue_valid[%0d]", u),
                  32'(issue_valid[u]), 32'(pick[u] >= 0));
            if (pick[u] >= 0)
                check(w == mq[pick[u]], "R1", $sformatf("issue_word[%0d]", u), w, mq[pick[u]]);
            check(unit_done[u] == e_done, "R8", $sformatf("unit_done[%0d]", u),
                  32'(unit_done[u]), 32'(e_done));
            if (issue_valid[u]) begin
                iss_cyc[w] = cyc;
                iss_num[w] = iss_num.exists(w) ? iss_num[w] + 1 : 1;
            end
        end
        if (full) full_seen++;
        // advance model
        acc = in_valid && !e_full;
        for (int k = 0; k < mq.size(); k++) if (!gone[k]) nq.push_back(mq[k]);
        for (int u = 0; u < NU; u++) begin
            if (ubusy[u] != 0) begin
                if (ucnt[u] == 0) ubusy[u] = 0;
                else ucnt[u] = ucnt[u] - 1;
            end
        end
        for (int u = 0; u < NU; u++) begin
            if (pick[u] >= 0) begin
                ubusy[u] = 1;
                ucnt[u]  = LAT - 1;
                udst[u]  = dstf(mq[pick[u]]);
            end
        end
        if (acc) begin
            nq.push_back(src_q.pop_front());
            sent++;
        end
        mq = nq;
        cyc++;
    endtask

    task automatic drain();
        bit any;
        do begin
            step();
            any = 1'b0;
            for (int u = 0; u < NU; u++) if (ubusy[u] != 0) any = 1'b1;
        end while (src_q.size() > 0 || mq.size() > 0 || any);
        step();
        step();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] p, a, b, i0, i1, i2, i3, i4;
        int bad;
        for (int u = 0; u < NU; u++) begin ubusy[u] = 0; ucnt[u] = 0; udst[u] = 0; end
        repeat (3) @(negedge clk);
        // R9: reset state
        check(full == 1'b0, "R9", "full in reset", 32'(full), 0);
        check(issue_valid == '0, "R9", "issue_valid in reset", 32'(issue_valid), 0);
        check(unit_done == '0, "R9", "unit_done in reset", 32'(unit_done), 0);
        rst_n = 1'b1;
        step();
        check(issue_valid == '0 && !full, "R9", "idle after reset", 32'(issue_valid), 0);

        // Scenario 1: held group released together, younger independent overtakes, stall
        p  = mk(1, 40, 90, 91, 92);
        i0 = mk(1, 1, 40, 93, 94);
        i1 = mk(1, 2, 40, 95, 96);
        i2 = mk(1, 3, 40, 97, 98);
        i3 = mk(1, 4, 101, 102, 103);
        i4 = mk(1, 5, 104, 105, 106);
        src_q = '{p, i0, i1, i2, i3, i4};
        drain();
        check(iss(i0) == iss(i1), "R7", "parallel release", 32'(iss(i1)), 32'(iss(i0)));
        check(iss(i2) > iss(i1), "R7", "no unit left for third", 32'(iss(i2)), 32'(iss(i1) + 1));
        check(iss(i3) < iss(i0), "R7", "younger overtakes", 32'(iss(i3)), 32'(iss(i0) - 1));
        check(full_seen > 0, "R2", "full reached", 32'(full_seen), 1);
        check(iss(i4) > iss(i3) + 1, "R2", "stalled while full", 32'(iss(i4)), 32'(iss(i3) + 2));

        // Scenario 2: true dependency through the S field, then pending hold
        p = mk(2, 40, 90, 91, 92);
        a = mk(2, 60, 40, 93, 94);
        b = mk(2, 61, 1, 2, 60);
        src_q = '{p, a, b};
        drain();
        check(iss(b) > iss(a), "R3", "reader after writer", 32'(iss(b)), 32'(iss(a) + 1));
        check(iss(b) == iss(a) + LAT + 1, "R6", "pending release", 32'(iss(b)), 32'(iss(a) + LAT + 1));

        // Scenario 3: younger writes a register the older reads
        p = mk(3, 40, 90, 91, 92);
        a = mk(3, 20, 40, 21, 95);
        b = mk(3, 21, 30, 31, 32);
        src_q = '{p, a, b};
        drain();
        check(iss(b) == iss(a) + 1, "R4", "reverse conflict", 32'(iss(b)), 32'(iss(a) + 1));

        // Scenario 4: same result register only
        p = mk(4, 40, 90, 91, 92);
        a = mk(4, 50, 40, 35, 36);
        b = mk(4, 50, 37, 38, 39);
        src_q = '{p, a, b};
        drain();
        check(iss(b) < iss(a), "R5", "same dest not blocking", 32'(iss(b)), 32'(iss(a) - 1));

        // Scenario 5: dependency through the Y field position
        p = mk(5, 40, 90, 91, 92);
        a = mk(5, 22, 40, 96, 97);
        b = mk(5, 23, 98, 22, 99);
        src_q = '{p, a, b};
        drain();
        check(iss(b) > iss(a), "R1", "Y field decoded", 32'(iss(b)), 32'(iss(a) + 1));

        // R10: every accepted word issued exactly once
        bad = 0;
        foreach (iss_num[w]) if (iss_num[w] != 1) bad++;
        check(iss_num.num() == sent, "R10", "distinct issued words", 32'(iss_num.num()), 32'(sent));
        check(bad == 0, "R10", "words issued more than once", 32'(bad), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule